// File: doc/BRIEF.md
# Dual-Write Dual-Read Lane-Masked Memory

This block stores 512 words of 18 bits and offers four ports that can all be used in the same clock cycle: two write ports (A and B) and two read ports (A and B). Each word is split into two 9-bit lanes, and every write port carries a two-bit lane mask, so a write can update either half of a word or both halves.

When both write ports hit the same address in the same cycle, a mode input decides what happens. With arbitration on, port A keeps every lane that both ports enable, and port B is told through a flag in that cycle. Lanes that only one port enables are still written. With arbitration off, the overlapping lanes are left undefined and no flag is raised. Reads are registered and take one cycle. A read of a word that is being written in the same cycle returns the contents from before the write.

Top module: `quad_access_ram`

## Requirements
- R1: A word written through write port A can be read back through either read port. The read data appears on the clock edge after the read is issued, and every address from 0 to 511 is usable.
- R2: Writes from both write ports to different addresses in the same cycle both take effect.
- R3: Both read ports return their own addressed words in the same cycle.
- R4: Lane mask bit 0 enables data bits 8:0 and lane mask bit 1 enables data bits 17:9. A lane whose mask bit is 0 keeps its stored value.
- R5: With `arb_mode` at 1, on a same-address write in one cycle, every lane both ports enable takes port A's data. Lanes that only port B enables take port B's data.
- R6: `wb_collide` is 1 in a cycle exactly when `arb_mode` is 1, both write enables are 1, both write addresses are equal and the two lane masks share at least one bit.
- R7: With `arb_mode` at 0, `wb_collide` stays 0. On a same-address write, lanes that only one port enables are written normally.
- R8: A read of an address that is written in the same cycle returns the word as it was before that write. The next read returns the new word.
- R9: While a read port's enable is 0, its read data output holds its last value, whatever the address or writes do.
- R10: While `rst_n` is 0, both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_mode | input | 1 | 1 turns on write-port arbitration |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | 9 | Write port A address |
| wa_lane | input | 2 | Write port A lane mask |
| wa_data | input | 18 | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | 9 | Write port B address |
| wb_lane | input | 2 | Write port B lane mask |
| wb_data | input | 18 | Write port B data |
| wb_collide | output | 1 | Port B lost at least one lane this cycle |
| ra_en | input | 1 | Read port A enable |
| ra_addr | input | 9 | Read port A address |
| ra_data | output | 18 | Read port A data, one cycle after the read |
| rb_en | input | 1 | Read port B enable |
| rb_addr | input | 9 | Read port B address |
| rb_data | output | 18 | Read port B data, one cycle after the read |

## Verification
The assertions assume that the write and read inputs are steady and known around each rising clock edge. They also assume that `arb_mode` only changes while no collision is in flight, because the collision flag is judged against the mode in the same cycle. The stimulus changes every input on the falling edge and sets the mode before each group of colliding writes. Lanes that collide while arbitration is off are never compared, because their contents are undefined.

// File: rtl/qram_pkg.sv
package qram_pkg;
  localparam int unsigned QRAM_DEPTH  = 512;
  localparam int unsigned QRAM_LANE_W = 9;
  localparam int unsigned QRAM_LANES  = 2;

  typedef enum logic {
    ARB_OFF = 1'b0,
    ARB_ON  = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/qram_rst_sync.sv
module qram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_r;
  logic [1:0] stage_nxt;

  always_comb stage_nxt = {stage_r[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_r <= '0;
    else        stage_r <= stage_nxt;
  end

  assign rst_n_sync = stage_r[1];
endmodule

// File: rtl/qram_wr_arb.sv
module qram_wr_arb
  import qram_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic              arb_mode,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_lane,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_lane,
  output logic [LANES-1:0]  a_we,
  output logic [LANES-1:0]  b_we,
  output logic              b_collide
);
  logic [LANES-1:0] b_req;
  logic [LANES-1:0] overlap;
  logic             same_word;
  logic             arbitrate;

  always_comb begin
    a_we      = a_en ? a_lane : '0;
    b_req     = b_en ? b_lane : '0;
    same_word = a_en && b_en && (a_addr == b_addr);
    overlap   = a_we & b_req;
    arbitrate = (arb_mode_e'(arb_mode) == ARB_ON) && same_word;
    b_we      = arbitrate ? (b_req & ~overlap) : b_req;
    b_collide = arbitrate && (|overlap);
  end
endmodule

// File: rtl/qram_lane_bank.sv
module qram_lane_bank #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned W      = 9
) (
  input  logic              clk,
  input  logic              wr_ok,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [W-1:0]      a_data,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [W-1:0]      b_data,
  input  logic [ADDR_W-1:0] ra_addr,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [W-1:0]      ra_word,
  output logic [W-1:0]      rb_word
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_ok && a_we) cells[a_addr] <= a_data;
    if (wr_ok && b_we) cells[b_addr] <= b_data;
  end

  assign ra_word = cells[ra_addr];
  assign rb_word = cells[rb_addr];
endmodule

// File: rtl/qram_rd_reg.sv
module qram_rd_reg #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/quad_access_ram.sv
module quad_access_ram
  import qram_pkg::*;
#(
  parameter int unsigned DEPTH  = QRAM_DEPTH,
  parameter int unsigned LANE_W = QRAM_LANE_W,
  parameter int unsigned LANES  = QRAM_LANES,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_mode,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [LANES-1:0]  wa_lane,
  input  logic [WORD_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [LANES-1:0]  wb_lane,
  input  logic [WORD_W-1:0] wb_data,
  output logic              wb_collide,
  input  logic              ra_en,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [WORD_W-1:0] ra_data,
  input  logic              rb_en,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [WORD_W-1:0] rb_data
);
  logic              rst_n_sync;
  logic [LANES-1:0]  a_we;
  logic [LANES-1:0]  b_we;
  logic [WORD_W-1:0] ra_word;
  logic [WORD_W-1:0] rb_word;

  qram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  qram_wr_arb #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wr_arb (
    .arb_mode  (arb_mode),
    .a_en      (wa_en),
    .a_addr    (wa_addr),
    .a_lane    (wa_lane),
    .b_en      (wb_en),
    .b_addr    (wb_addr),
    .b_lane    (wb_lane),
    .a_we      (a_we),
    .b_we      (b_we),
    .b_collide (wb_collide)
  );

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    qram_lane_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .W(LANE_W)) u_bank (
      .clk     (clk),
      .wr_ok   (rst_n_sync),
      .a_we    (a_we[gl]),
      .a_addr  (wa_addr),
      .a_data  (wa_data[gl*LANE_W +: LANE_W]),
      .b_we    (b_we[gl]),
      .b_addr  (wb_addr),
      .b_data  (wb_data[gl*LANE_W +: LANE_W]),
      .ra_addr (ra_addr),
      .rb_addr (rb_addr),
      .ra_word (ra_word[gl*LANE_W +: LANE_W]),
      .rb_word (rb_word[gl*LANE_W +: LANE_W])
    );
  end

  qram_rd_reg #(.W(WORD_W)) u_rd_a (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (ra_en),
    .d     (ra_word),
    .q     (ra_data)
  );

  qram_rd_reg #(.W(WORD_W)) u_rd_b (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (rb_en),
    .d     (rb_word),
    .q     (rb_data)
  );
endmodule

// File: rtl/qram_checker.sv
module qram_checker #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 2,
  parameter int unsigned WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arb_mode,
  input logic              wa_en,
  input logic [ADDR_W-1:0] wa_addr,
  input logic [LANES-1:0]  wa_lane,
  input logic              wb_en,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [LANES-1:0]  wb_lane,
  input logic              wb_collide,
  input logic              ra_en,
  input logic [WORD_W-1:0] ra_data,
  input logic              rb_en,
  input logic [WORD_W-1:0] rb_data
);
  assert_collide_needs_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_collide |-> arb_mode);

  assert_collide_same_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_collide |-> (wa_en && wb_en && (wa_addr == wb_addr)));

  assert_collide_needs_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_collide |-> (|(wa_lane & wb_lane)));

  assert_hold_port_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_en |=> $stable(ra_data));

  assert_hold_port_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_en |=> $stable(rb_data));

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |-> (ra_data == '0 && rb_data == '0));
endmodule

bind quad_access_ram qram_checker #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arb_mode   (arb_mode),
  .wa_en      (wa_en),
  .wa_addr    (wa_addr),
  .wa_lane    (wa_lane),
  .wb_en      (wb_en),
  .wb_addr    (wb_addr),
  .wb_lane    (wb_lane),
  .wb_collide (wb_collide),
  .ra_en      (ra_en),
  .ra_data    (ra_data),
  .rb_en      (rb_en),
  .rb_data    (rb_data)
);

// File: tb/test_quad_access_ram.sv
module test_quad_access_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int WW = 18;
  localparam int NL = 2;

  logic          clk;
  logic          rst_n;
  logic          arb_mode;
  logic          wa_en, wb_en, ra_en, rb_en;
  logic [AW-1:0] wa_addr, wb_addr, ra_addr, rb_addr;
  logic [NL-1:0] wa_lane, wb_lane;
  logic [WW-1:0] wa_data, wb_data;
  logic          wb_collide;
  logic [WW-1:0] ra_data, rb_data;

  logic [WW-1:0] model [512];
  logic [WW-1:0] got_a, got_b;
  logic          seen_collide;
  int            checks;
  int            fails;
  bit            done;

  quad_access_ram i_quad_access_ram (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_lane(wa_lane), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_lane(wb_lane), .wb_data(wb_data),
    .wb_collide(wb_collide),
    .ra_en(ra_en), .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_en(rb_en), .rb_addr(rb_addr), .rb_data(rb_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WW-1:0] lane_bits(input logic [NL-1:0] l);
    return {{9{l[1]}}, {9{l[0]}}};
  endfunction

  task automatic check(input string req, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wa_en = 0; wb_en = 0; ra_en = 0; rb_en = 0;
    wa_addr = '0; wb_addr = '0; ra_addr = '0; rb_addr = '0;
    wa_lane = '0; wb_lane = '0; wa_data = '0; wb_data = '0;
  endtask

  // one write cycle on both ports; model follows R4/R5
  task automatic wr2(input logic ae, input logic [AW-1:0] aa, input logic [NL-1:0] al, input logic [WW-1:0] ad,
                     input logic be, input logic [AW-1:0] ba, input logic [NL-1:0] bl, input logic [WW-1:0] bd);
    logic [WW-1:0] am, bm;
    @(negedge clk);
    wa_en = ae; wa_addr = aa; wa_lane = al; wa_data = ad;
    wb_en = be; wb_addr = ba; wb_lane = bl; wb_data = bd;
    #1 seen_collide = wb_collide;
    am = ae ? lane_bits(al) : '0;
    bm = be ? lane_bits(bl) : '0;
    if (ae && be && aa == ba) bm = bm & ~am;
    if (be) model[ba] = (model[ba] & ~bm) | (bd & bm);
    if (ae) model[aa] = (model[aa] & ~am) | (ad & am);
    @(negedge clk);
    idle();
  endtask

  task automatic wr_a(input logic [AW-1:0] a, input logic [WW-1:0] d);
    wr2(1, a, 2'b11, d, 0, '0, 2'b00, '0);
  endtask

  task automatic rd2(input logic [AW-1:0] a, input logic [AW-1:0] b);
    @(negedge clk);
    ra_en = 1; ra_addr = a; rb_en = 1; rb_addr = b;
    @(negedge clk);
    got_a = ra_data; got_b = rb_data;
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; arb_mode = 0; idle();
    repeat (3) @(negedge clk);
    check("R10", "ra_data in reset", ra_data, '0);
    check("R10", "rb_data in reset", rb_data, '0);
    check("R10", "collide in reset", {17'b0, wb_collide}, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_basic();
    wr_a(9'd5, 18'h2A5A5);
    wr_a(9'd511, 18'h3FFFF);
    wr_a(9'd0, 18'h12345);
    rd2(9'd5, 9'd511);
    check("R1", "port A addr 5", got_a, model[5]);
    check("R3", "port B addr 511", got_b, model[511]);
    rd2(9'd511, 9'd0);
    check("R1", "port A addr 511", got_a, 18'h3FFFF);
    check("R3", "port B addr 0", got_b, 18'h12345);
  endtask

  task automatic t_dual_write();
    wr2(1, 9'd10, 2'b11, 18'h11111, 1, 9'd20, 2'b11, 18'h22222);
    rd2(9'd10, 9'd20);
    check("R2", "port A write landed", got_a, 18'h11111);
    check("R2", "port B write landed", got_b, 18'h22222);
  endtask

  task automatic t_lanes();
    wr_a(9'd30, 18'h3FFFF);
    wr2(1, 9'd30, 2'b01, 18'h00000, 0, '0, 2'b00, '0);
    rd2(9'd30, 9'd30);
    check("R4", "lower lane only", got_a, 18'h3FE00);
    wr2(0, '0, 2'b00, '0, 1, 9'd30, 2'b10, 18'h155AA);
    rd2(9'd30, 9'd30);
    check("R4", "upper lane via port B", got_b, model[30]);
    check("R4", "upper lane expected", got_b, 18'h15400);
  endtask

  task automatic t_arb();
    arb_mode = 1;
    wr_a(9'd40, '0);
    wr_a(9'd41, '0);
    wr2(1, 9'd40, 2'b11, 18'h0AAAA, 1, 9'd40, 2'b11, 18'h15555);
    check("R6", "flag on full collision", {17'b0, seen_collide}, 18'd1);
    rd2(9'd40, 9'd40);
    check("R5", "port A wins both lanes", got_a, 18'h0AAAA);
    wr2(1, 9'd41, 2'b01, 18'h3FFFF, 1, 9'd41, 2'b10, 18'h3FFFF);
    check("R6", "no flag on disjoint lanes", {17'b0, seen_collide}, 18'd0);
    rd2(9'd41, 9'd41);
    check("R5", "disjoint lanes both land", got_a, 18'h3FFFF);
    wr2(1, 9'd41, 2'b11, 18'h00F0F, 1, 9'd41, 2'b01, 18'h3F0F0);
    check("R6", "flag on partial overlap", {17'b0, seen_collide}, 18'd1);
    rd2(9'd41, 9'd41);
    check("R5", "port A wins shared lane", got_a, 18'h00F0F);
    wr2(1, 9'd42, 2'b11, 18'h1, 1, 9'd43, 2'b11, 18'h2);
    check("R6", "no flag on different addresses", {17'b0, seen_collide}, 18'd0);
    arb_mode = 0;
  endtask

  task automatic t_noarb();
    arb_mode = 0;
    wr_a(9'd50, '0);
    wr2(1, 9'd50, 2'b01, 18'h0FFFF, 1, 9'd50, 2'b11, 18'h2AAAA);
    check("R7", "no flag without arbitration", {17'b0, seen_collide}, 18'd0);
    rd2(9'd50, 9'd50);
    check("R7", "B-only upper lane written", got_a & 18'h3FE00, 18'h2AAAA & 18'h3FE00);
  endtask

  task automatic t_rbw();
    wr_a(9'd60, 18'h01234);
    @(negedge clk);
    wa_en = 1; wa_addr = 9'd60; wa_lane = 2'b11; wa_data = 18'h3C3C3;
    ra_en = 1; ra_addr = 9'd60;
    @(negedge clk);
    got_a = ra_data;
    idle();
    model[60] = 18'h3C3C3;
    check("R8", "old data on same-cycle read", got_a, 18'h01234);
    rd2(9'd60, 9'd60);
    check("R8", "new data on next read", got_a, 18'h3C3C3);
  endtask

  task automatic t_hold();
    rd2(9'd5, 9'd511);
    @(negedge clk);
    ra_addr = 9'd0; rb_addr = 9'd0;
    wa_en = 1; wa_addr = 9'd5; wa_lane = 2'b11; wa_data = 18'h00007;
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check("R9", "port A held", ra_data, 18'h2A5A5);
    check("R9", "port B held", rb_data, 18'h3FFFF);
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    t_reset();
    t_basic();
    t_dual_write();
    t_lanes();
    t_arb();
    t_noarb();
    t_rbw();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule